// File: doc/BRIEF.md
# Power and Clock Mode Controller

This block holds the power-control and oscillator-control bits of a small microcontroller. From them it works out one operating mode and drives the gating enables for the CPU clock, the peripheral clock and three oscillators: a crystal, a fast RC and a slow RC that also feeds the watchdog. Software changes the bits through a narrow register write port. Hardware clears the sleep bits when a wake-up event arrives, so the CPU restarts on the oscillator it was using before it went to sleep.

Two 4-bit control words are written through `wr_sel`. The oscillator word (`wr_sel`=1) has bit 0 for the crystal enable, bit 1 for the fast RC enable, bit 2 for the source select (1 = crystal, 0 = fast RC) and bit 3 for the slow RC shut-off. The power word (`wr_sel`=0) has bit 0 for idle and bit 1 for power-down. Its bits 3:2 are ignored. The block carries no data stream, so every pin is a plain level with no handshake. A written value takes effect on the clock edge where `wr_en` is sampled high. All outputs are decoded from the registered state, so they show the new value right after that edge.

Top module: `pwr_clk_mode_ctrl`

## Requirements
- R1: While `rst_n` is low, power-down and idle clear and slow shut-off clears. The source select and the crystal enable take the value of `rst_osc_xtal`, and the fast RC enable takes its inverse. After reset the mode is 0 when `rst_osc_xtal`=1 and 1 when it is 0.
- R2: With power-down and idle clear and the selected oscillator enabled, the mode is 0 (run on crystal) when the source select is 1 and 1 (run on fast RC) when it is 0. `cpu_clk_en` and `per_clk_en` are both 1.
- R3: With power-down clear and the selected oscillator disabled, the mode is 2 (rescue) when slow shut-off is 0 and 7 (no clock) when it is 1. The idle bit has no effect here. In rescue, both clock enables are 1. In mode 7, `invalid` is 1 and both clock enables are 0. `invalid` is 0 in every other mode.
- R4: With power-down clear, idle set and the selected oscillator enabled, the mode is 3 (idle on crystal) or 4 (idle on fast RC), following the source select. `cpu_clk_en` is 0 and `per_clk_en` is 1.
- R5: With power-down set, the mode is 5 (sleep, watchdog still clocked) when slow shut-off is 0 and 6 (full sleep) when it is 1. This holds whatever the other bits are. Both clock enables are 0.
- R6: `xtal_osc_en` and `frc_osc_en` follow their enable bits while power-down is clear, and are 0 while it is set. `slow_osc_en` is the inverse of slow shut-off. `osc_sel` equals the source select.
- R7: While idle is set and power-down is clear, a cycle with `irq_pending` or any `ext_int` bit high clears idle at that edge.
- R8: While power-down is set, a cycle with any `ext_int` bit high clears both power-down and idle. `irq_pending` alone leaves the block asleep.
- R9: A wake-up leaves the oscillator word unchanged, so the mode returns to the run mode that was in force before sleep.
- R10: A wake event and a power-word write in the same cycle resolve in favour of the wake, which clears the bits it owns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rst_osc_xtal | input | 1 | Reset source choice: 1 crystal, 0 fast RC |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 1 oscillator word, 0 power word |
| wr_data | input | 4 | Write data |
| irq_pending | input | 1 | Any enabled interrupt request |
| ext_int | input | N_EXT (2) | Enabled external interrupt requests |
| mode | output | 3 | Operating mode code |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| per_clk_en | output | 1 | Peripheral clock gate enable |
| xtal_osc_en | output | 1 | Crystal oscillator enable |
| frc_osc_en | output | 1 | Fast RC oscillator enable |
| slow_osc_en | output | 1 | Slow RC oscillator enable |
| osc_sel | output | 1 | Main source select: 1 crystal, 0 fast RC |
| invalid | output | 1 | No active clock configuration |

## Verification
The bench runs every oscillator word against every power word, starting from both reset choices. It compares the mode and all enables with a decode worked out arithmetically in the bench. This separates the priority of power-down over source availability, the priority of source availability over idle, and the rescue case from the no-clock case. Wake sequences are then tried with `irq_pending` alone, with each `ext_int` bit, and with a wake colliding with a write. These show that only external interrupts end power-down, and that a wake restores the earlier run mode without touching the oscillator word.

// File: rtl/pcm_pkg.sv
package pcm_pkg;
  localparam int CTL_W  = 4;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_RUN_XTAL  = 3'd0,
    MODE_RUN_FRC   = 3'd1,
    MODE_RESCUE    = 3'd2,
    MODE_IDLE_XTAL = 3'd3,
    MODE_IDLE_FRC  = 3'd4,
    MODE_SLEEP_WD  = 3'd5,
    MODE_SLEEP_ALL = 3'd6,
    MODE_NO_CLOCK  = 3'd7
  } pcm_mode_e;

  // field order matches write-data bit positions (MSB first)
  typedef struct packed {
    logic slow_off;
    logic src_xtal;
    logic frc_en;
    logic xtal_en;
  } osc_ctl_t;

  typedef struct packed {
    logic pd;
    logic idle;
  } pwr_ctl_t;
endpackage

// File: rtl/pcm_regs.sv
module pcm_regs
  import pcm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rst_osc_xtal,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [CTL_W-1:0] wr_data,
  input  logic             irq_any,
  input  logic             ext_wake,
  output osc_ctl_t         osc_q,
  output pwr_ctl_t         pwr_q
);
  pwr_ctl_t pwr_d;

  always_comb begin
    pwr_d = pwr_q;
    if (wr_en && !wr_sel) pwr_d = pwr_ctl_t'(wr_data[1:0]);
    // wake-ups take priority over a colliding write
    if (pwr_q.pd && ext_wake) begin
      pwr_d.pd   = 1'b0;
      pwr_d.idle = 1'b0;
    end else if (!pwr_q.pd && pwr_q.idle && (irq_any || ext_wake)) begin
      pwr_d.idle = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osc_q.slow_off <= 1'b0;
      osc_q.src_xtal <= rst_osc_xtal;
      osc_q.frc_en   <= !rst_osc_xtal;
      osc_q.xtal_en  <= rst_osc_xtal;
      pwr_q          <= '0;
    end else begin
      if (wr_en && wr_sel) osc_q <= osc_ctl_t'(wr_data);
      pwr_q <= pwr_d;
    end
  end
endmodule

// File: rtl/pcm_decode.sv
module pcm_decode
  import pcm_pkg::*;
(
  input  osc_ctl_t  osc,
  input  pwr_ctl_t  pwr,
  output pcm_mode_e mode
);
  logic src_alive;

  always_comb begin
    src_alive = osc.src_xtal ? osc.xtal_en : osc.frc_en;
    if (pwr.pd)
      mode = osc.slow_off ? MODE_SLEEP_ALL : MODE_SLEEP_WD;
    else if (!src_alive)
      mode = osc.slow_off ? MODE_NO_CLOCK : MODE_RESCUE;
    else if (pwr.idle)
      mode = osc.src_xtal ? MODE_IDLE_XTAL : MODE_IDLE_FRC;
    else
      mode = osc.src_xtal ? MODE_RUN_XTAL : MODE_RUN_FRC;
  end
endmodule

// File: rtl/pcm_gate.sv
module pcm_gate
  import pcm_pkg::*;
(
  input  pcm_mode_e mode,
  input  osc_ctl_t  osc,
  input  logic      pd,
  output logic      cpu_clk_en,
  output logic      per_clk_en,
  output logic      xtal_osc_en,
  output logic      frc_osc_en,
  output logic      slow_osc_en,
  output logic      osc_sel,
  output logic      invalid
);
  always_comb begin
    cpu_clk_en = 1'b0;
    per_clk_en = 1'b0;
    unique case (mode)
      MODE_RUN_XTAL, MODE_RUN_FRC, MODE_RESCUE: begin
        cpu_clk_en = 1'b1;
        per_clk_en = 1'b1;
      end
      MODE_IDLE_XTAL, MODE_IDLE_FRC: per_clk_en = 1'b1;
      default: ;
    endcase
    xtal_osc_en = osc.xtal_en && !pd;
    frc_osc_en  = osc.frc_en && !pd;
    slow_osc_en = !osc.slow_off;
    osc_sel     = osc.src_xtal;
    invalid     = (mode == MODE_NO_CLOCK);
  end
endmodule

// File: rtl/pwr_clk_mode_ctrl.sv
module pwr_clk_mode_ctrl
  import pcm_pkg::*;
#(
  parameter int N_EXT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rst_osc_xtal,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [CTL_W-1:0]  wr_data,
  input  logic              irq_pending,
  input  logic [N_EXT-1:0]  ext_int,
  output logic [MODE_W-1:0] mode,
  output logic              cpu_clk_en,
  output logic              per_clk_en,
  output logic              xtal_osc_en,
  output logic              frc_osc_en,
  output logic              slow_osc_en,
  output logic              osc_sel,
  output logic              invalid
);
  osc_ctl_t  osc_q;
  pwr_ctl_t  pwr_q;
  pcm_mode_e mode_w;

  pcm_regs u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .rst_osc_xtal (rst_osc_xtal),
    .wr_en        (wr_en),
    .wr_sel       (wr_sel),
    .wr_data      (wr_data),
    .irq_any      (irq_pending),
    .ext_wake     (|ext_int),
    .osc_q        (osc_q),
    .pwr_q        (pwr_q)
  );

  pcm_decode u_decode (
    .osc  (osc_q),
    .pwr  (pwr_q),
    .mode (mode_w)
  );

  pcm_gate u_gate (
    .mode        (mode_w),
    .osc         (osc_q),
    .pd          (pwr_q.pd),
    .cpu_clk_en  (cpu_clk_en),
    .per_clk_en  (per_clk_en),
    .xtal_osc_en (xtal_osc_en),
    .frc_osc_en  (frc_osc_en),
    .slow_osc_en (slow_osc_en),
    .osc_sel     (osc_sel),
    .invalid     (invalid)
  );

  assign mode = mode_w;
endmodule

// File: rtl/pcm_chk.sv
module pcm_chk #(
  parameter int N_EXT = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             irq_pending,
  input logic [N_EXT-1:0] ext_int,
  input logic [2:0]       mode,
  input logic             cpu_clk_en,
  input logic             per_clk_en,
  input logic             xtal_osc_en,
  input logic             frc_osc_en,
  input logic             slow_osc_en,
  input logic             osc_sel,
  input logic             invalid
);
  // R2
  cpu_needs_per_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_clk_en |-> per_clk_en);

  // R3
  invalid_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    invalid |-> (!cpu_clk_en && !per_clk_en));

  // R6
  per_has_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    per_clk_en |-> ((osc_sel ? xtal_osc_en : frc_osc_en) || slow_osc_en));

  // R7
  idle_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == 3'd3 || mode == 3'd4) && irq_pending && !wr_en)
      |=> (mode != 3'd3 && mode != 3'd4));

  // R8
  sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == 3'd5 || mode == 3'd6) && !(|ext_int) && !wr_en) |=> $stable(mode));

  // R9
  wake_keeps_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == 3'd5 || mode == 3'd6) && (|ext_int) && !wr_en) |=> $stable(osc_sel));
endmodule

bind pwr_clk_mode_ctrl pcm_chk #(.N_EXT(N_EXT)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .irq_pending (irq_pending),
  .ext_int     (ext_int),
  .mode        (mode),
  .cpu_clk_en  (cpu_clk_en),
  .per_clk_en  (per_clk_en),
  .xtal_osc_en (xtal_osc_en),
  .frc_osc_en  (frc_osc_en),
  .slow_osc_en (slow_osc_en),
  .osc_sel     (osc_sel),
  .invalid     (invalid)
);

// File: tb/pwr_clk_mode_ctrl_tb_top.sv
module pwr_clk_mode_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rst_osc_xtal = 1'b1;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [3:0] wr_data = '0;
  logic       irq_pending = 1'b0;
  logic [1:0] ext_int = '0;
  logic [2:0] mode;
  logic       cpu_clk_en, per_clk_en, xtal_osc_en, frc_osc_en, slow_osc_en, osc_sel, invalid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  pwr_clk_mode_ctrl #(.N_EXT(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .rst_osc_xtal(rst_osc_xtal),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .irq_pending(irq_pending), .ext_int(ext_int),
    .mode(mode), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
    .xtal_osc_en(xtal_osc_en), .frc_osc_en(frc_osc_en),
    .slow_osc_en(slow_osc_en), .osc_sel(osc_sel), .invalid(invalid)
  );

  // Expected mode from the requirement rules (osc word o, power word p)
  function automatic logic [2:0] exp_mode(input logic [3:0] o, input logic [1:0] p);
    logic alive;
    alive = o[2] ? o[0] : o[1];
    if (p[1])       return o[3] ? 3'd6 : 3'd5;
    else if (!alive) return o[3] ? 3'd7 : 3'd2;
    else if (p[0])  return o[2] ? 3'd3 : 3'd4;
    else            return o[2] ? 3'd0 : 3'd1;
  endfunction

  // packed: mode, cpu, per, xtal, frc, slow, sel, invalid
  function automatic logic [9:0] exp_all(input logic [3:0] o, input logic [1:0] p);
    logic [2:0] m;
    m = exp_mode(o, p);
    return {m, (m <= 3'd2), (m <= 3'd4), o[0] & ~p[1], o[1] & ~p[1],
            ~o[3], o[2], (m == 3'd7)};
  endfunction

  task automatic check(input string req, input logic [9:0] exp);
    logic [9:0] act;
    act = {mode, cpu_clk_en, per_clk_en, xtal_osc_en, frc_osc_en,
           slow_osc_en, osc_sel, invalid};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got mode=%0d en=%b, expected mode=%0d en=%b",
               req, act[9:7], act[6:0], exp[9:7], exp[6:0]);
    end
  endtask

  task automatic do_reset(input logic src);
    @(negedge clk);
    rst_osc_xtal = src;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic sel, input logic [3:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input logic irq, input logic [1:0] ei);
    @(negedge clk);
    irq_pending = irq; ext_int = ei;
    @(negedge clk);
    irq_pending = 1'b0; ext_int = '0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    // R1: reset state for both source choices
    for (int r = 0; r < 2; r++) begin
      do_reset(r[0]);
      check("R1 reset", exp_all({1'b0, r[0], ~r[0], r[0]}, 2'b00));
    end

    // R2 R3 R4 R5 R6: sweep every oscillator word against every power word
    for (int r = 0; r < 2; r++)
      for (int o = 0; o < 16; o++)
        for (int p = 0; p < 4; p++) begin
          do_reset(r[0]);
          wr(1'b1, o[3:0]);
          wr(1'b0, {2'b11, p[1:0]});  // upper bits ignored
          check("R2/R3/R4/R5/R6 sweep", exp_all(o[3:0], p[1:0]));
        end

    // R7 R9: idle on crystal, woken by irq_pending
    do_reset(1'b1);
    wr(1'b0, 4'b0001);
    check("R4 idle crystal", exp_all(4'b0101, 2'b01));
    pulse(1'b1, 2'b00);
    check("R7 R9 idle wake by irq", exp_all(4'b0101, 2'b00));

    // R7: idle on fast RC, woken by ext_int[0]
    do_reset(1'b0);
    wr(1'b0, 4'b0001);
    check("R4 idle fast RC", exp_all(4'b0010, 2'b01));
    pulse(1'b0, 2'b01);
    check("R7 idle wake by ext_int", exp_all(4'b0010, 2'b00));

    // R8: power-down ignores irq_pending, wakes on ext_int[1]
    do_reset(1'b1);
    wr(1'b0, 4'b0011);
    check("R5 sleep with watchdog", exp_all(4'b0101, 2'b11));
    pulse(1'b1, 2'b00);
    check("R8 irq alone ignored in sleep", exp_all(4'b0101, 2'b11));
    pulse(1'b0, 2'b10);
    check("R8 R9 sleep wake by ext_int", exp_all(4'b0101, 2'b00));

    // R3: no-clock configuration, then R5 full sleep and wake
    wr(1'b1, 4'b1110);
    check("R3 no clock", exp_all(4'b1110, 2'b00));
    wr(1'b1, 4'b1101);
    wr(1'b0, 4'b0010);
    check("R5 full sleep", exp_all(4'b1101, 2'b10));
    pulse(1'b0, 2'b01);
    check("R9 full sleep wake", exp_all(4'b1101, 2'b00));

    // R10: wake collides with a power-word write that sets sleep again
    wr(1'b0, 4'b0010);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 1'b0; wr_data = 4'b0010; ext_int = 2'b01;
    @(negedge clk);
    wr_en = 1'b0; ext_int = '0;
    check("R10 wake beats write", exp_all(4'b1101, 2'b00));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule